// File: doc/BRIEF.md
# Reset/Sleep Pulse-Width Discriminator

This block lets a single active-high control pin carry two commands. It measures, in clock cycles, how long the pin stays asserted. A brief assertion asks for a datapath reset. A sustained assertion asks the device to power down.

The pin is first brought into the clock domain through a two-stage synchronizer. A saturating counter then tracks how long the synchronized level has been high. A short assertion of one to three cycles produces a single-cycle reset pulse when the level drops. Once the count reaches four, the sleep level rises and stays high for as long as the pin is held. No reset pulse follows a long assertion.

When the pin is tied low, the block stays idle and issues neither command. Shutting down the analog circuits and letting them settle after wake-up are handled elsewhere.

Top module: `dualfn_pin_ctl`

## Requirements
- R1: While the control pin stays low, `dp_rst_o` and `sleep_o` both stay 0.
- R2: While `rst_ni` is low, and on the first cycle after its release, both outputs are 0.
- R3: Number the first rising clock edge that samples the pin high as edge 1. If the pin is sampled high on exactly N consecutive edges with 1 <= N <= 3, then `dp_rst_o` is 1 for exactly one cycle, in the cycle that follows edge N+3.
- R4: An assertion of 1 to 3 sampled cycles never raises `sleep_o`.
- R5: For an assertion of N >= 4 sampled cycles, `sleep_o` first goes high in the cycle that follows edge 6.
- R6: For an assertion of N >= 4 sampled cycles, `sleep_o` stays high continuously through the cycle that follows edge N+2, and it is 0 after edge N+3.
- R7: An assertion of 4 or more cycles issues no reset pulse, whatever its length. The length counter saturates at 4, so an assertion of 41 cycles also produces no pulse.
- R8: Two short assertions separated by a single low cycle each produce their own one-cycle reset pulse.
- R9: `dp_rst_o` and `sleep_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| ctl_pin_i | input | 1 | Asynchronous control pin, active high |
| dp_rst_o | output | 1 | Single-cycle datapath reset pulse |
| sleep_o | output | 1 | Power-down request level |

## Verification
If the length counter holds a wrong value, the fault shows up at the port when the pin falls. A length that wrapped or was lost either produces a spurious reset pulse after a long hold, or drops the pulse after a short one. Either way it appears three edges after the last high sample. A fault in sleep entry moves its rising edge away from edge 6, which is visible within one cycle. A fault in sleep release moves its falling edge away from edge N+3. A broken synchronizer shifts every event by whole cycles, so the directed tests check exact cycle positions and not just event counts.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_RESET = 2'd1,
    EV_SLEEP = 2'd2
  } rsd_event_e;

  // Next run length: zero when the level is low, otherwise one more, capped at lim.
  function automatic int run_len_next(int cur, bit hi, int lim);
    if (!hi) return 0;
    if (cur >= lim) return lim;
    return cur + 1;
  endfunction

  // A run counts as short when it is nonzero and below the sleep threshold.
  function automatic bit run_is_short(int len, int lim);
    return (len > 0) && (len < lim);
  endfunction

endpackage

// File: rtl/rsd_sync.sv
module rsd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsd_len_cnt.sv
module rsd_len_cnt #(
  parameter int LIMIT = 4,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          level_i,
  output logic [CW-1:0] len_q_o,
  output logic [CW-1:0] len_d_o
);
  logic [CW-1:0] len_q;

  assign len_d_o = CW'(rsd_pkg::run_len_next(int'(len_q), level_i, LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) len_q <= '0;
    else         len_q <= len_d_o;
  end

  assign len_q_o = len_q;
endmodule

// File: rtl/rsd_decide.sv
module rsd_decide #(
  parameter int LIMIT = 4,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          level_i,
  input  logic [CW-1:0] len_q_i,
  input  logic [CW-1:0] len_d_i,
  output rsd_pkg::rsd_event_e evt_o,
  output logic          pulse_o,
  output logic          sleep_o
);
  import rsd_pkg::*;

  logic pulse_q, sleep_q;
  logic fire_rst, want_sleep;

  // A reset fires when a short run has just ended.
  assign fire_rst   = !level_i && run_is_short(int'(len_q_i), LIMIT);
  assign want_sleep = level_i && (int'(len_d_i) >= LIMIT);

  always_comb begin
    if (fire_rst)        evt_o = EV_RESET;
    else if (want_sleep) evt_o = EV_SLEEP;
    else                 evt_o = EV_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      pulse_q <= (evt_o == EV_RESET);
      sleep_q <= (evt_o == EV_SLEEP);
    end
  end

  assign pulse_o = pulse_q;
  assign sleep_o = sleep_q;
endmodule

// File: rtl/dualfn_pin_ctl.sv
module dualfn_pin_ctl #(
  parameter int SYNC_STAGES = 2,
  parameter int SLEEP_LEN   = 4,
  localparam int CW         = $clog2(SLEEP_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_pin_i,
  output logic dp_rst_o,
  output logic sleep_o
);
  logic          ctl_sync;
  logic [CW-1:0] len_cnt;
  logic [CW-1:0] len_nxt;
  rsd_pkg::rsd_event_e evt;

  rsd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ctl_pin_i),
    .q_o    (ctl_sync)
  );

  rsd_len_cnt #(.LIMIT(SLEEP_LEN)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (ctl_sync),
    .len_q_o (len_cnt),
    .len_d_o (len_nxt)
  );

  rsd_decide #(.LIMIT(SLEEP_LEN)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (ctl_sync),
    .len_q_i (len_cnt),
    .len_d_i (len_nxt),
    .evt_o   (evt),
    .pulse_o (dp_rst_o),
    .sleep_o (sleep_o)
  );
endmodule

// File: rtl/dualfn_pin_ctl_chk.sv
module dualfn_pin_ctl_chk #(
  parameter int SLEEP_LEN = 4,
  localparam int CW       = $clog2(SLEEP_LEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_s,
  input logic [CW-1:0] cnt,
  input logic          rst_pulse,
  input logic          sleep
);
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_pulse && sleep)); // R9

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse); // R3

  AST_PULSE_SHORT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse) |-> ($past(cnt) > 0 && int'($past(cnt)) < SLEEP_LEN)); // R7

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= SLEEP_LEN); // R7

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> int'(cnt) == SLEEP_LEN); // R5

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && ctl_s) |=> sleep); // R6

  AST_SLEEP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_s |=> !sleep); // R6
endmodule

bind dualfn_pin_ctl dualfn_pin_ctl_chk #(.SLEEP_LEN(SLEEP_LEN)) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .ctl_s     (ctl_sync),
  .cnt       (len_cnt),
  .rst_pulse (dp_rst_o),
  .sleep     (sleep_o)
);

// File: tb/sim_dualfn_pin_ctl.sv
module sim_dualfn_pin_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic dp_rst, sleep;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dualfn_pin_ctl u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ctl_pin_i (pin),
    .dp_rst_o  (dp_rst),
    .sleep_o   (sleep)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Hold the pin high for n sampled edges, then watch for n+10 edges.
  task automatic run_len(int n);
    int p_cnt = 0, p_at = -1, s_cnt = 0, s_first = -1, s_last = -1, both = 0;
    @(negedge clk);
    pin = 1'b1;
    for (int k = 1; k <= n + 10; k++) begin
      @(negedge clk);
      if (k == n) pin = 1'b0;
      if (dp_rst) begin p_cnt++; p_at = k; end
      if (sleep) begin
        s_cnt++;
        if (s_first < 0) s_first = k;
        s_last = k;
      end
      if (dp_rst && sleep) both++;
    end
    chk(both == 0, "R9 overlap", both, 0);
    if (n < 4) begin
      chk(p_cnt == 1, "R3 pulse count", p_cnt, 1);
      chk(p_at == n + 3, "R3 pulse cycle", p_at, n + 3);
      chk(s_cnt == 0, "R4 sleep on short", s_cnt, 0);
    end else begin
      chk(p_cnt == 0, "R7 no pulse on long", p_cnt, 0);
      chk(s_first == 6, "R5 sleep rise", s_first, 6);
      chk(s_last == n + 2, "R6 sleep last", s_last, n + 2);
      chk(s_cnt == n - 3, "R6 sleep continuous", s_cnt, n - 3);
    end
  endtask

  task automatic t_reset_state();
    chk(dp_rst == 1'b0 && sleep == 1'b0, "R2 in reset", {dp_rst, sleep}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dp_rst == 1'b0 && sleep == 1'b0, "R2 after release", {dp_rst, sleep}, 0);
  endtask

  task automatic t_idle();
    int hits = 0;
    pin = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (dp_rst || sleep) hits++;
    end
    chk(hits == 0, "R1 idle low", hits, 0);
  endtask

  task automatic t_back_to_back();
    int p_cnt = 0, p1 = -1, p2 = -1;
    @(negedge clk);
    pin = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (k == 2) pin = 1'b0;
      if (k == 3) pin = 1'b1;
      if (k == 6) pin = 1'b0;
      if (dp_rst) begin
        p_cnt++;
        if (p1 < 0) p1 = k; else p2 = k;
      end
    end
    chk(p_cnt == 2, "R8 pulse count", p_cnt, 2);
    chk(p1 == 5, "R8 first pulse", p1, 5);
    chk(p2 == 9, "R8 second pulse", p2, 9);
  endtask

  task automatic t_por_in_sleep();
    int hits = 0;
    @(negedge clk);
    pin = 1'b1;
    repeat (10) @(negedge clk);
    chk(sleep == 1'b1, "R5 sleep before por", sleep, 1);
    rst_n = 1'b0;
    #1;
    chk(dp_rst == 1'b0 && sleep == 1'b0, "R2 por clears", {dp_rst, sleep}, 0);
    pin = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (dp_rst || sleep) hits++;
    end
    chk(hits == 0, "R2 quiet after por", hits, 0);
  endtask

  initial begin
    t_reset_state();
    t_idle();
    for (int n = 1; n <= 3; n++) run_len(n);
    run_len(4);
    run_len(5);
    run_len(9);
    run_len(41);
    t_back_to_back();
    t_idle();
    t_por_in_sleep();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule